// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage in-order pipeline. It resolves read-after-write dependencies between ALU instructions without stalling. Two instructions ahead of the consumer may still be carrying results that the register file does not yet hold. One is the instruction in the execute/memory slot, which holds an ALU result. The other is in the memory/writeback slot, which holds the value being written back. For each of its two ALU operands, the consumer gives the source register number it read. The block compares that number with the destination number and write flag of each older instruction. From the result it derives a 2-bit selection for that operand.

The selections steer two three-way operand multiplexers. Each multiplexer picks the register-file value, the execute/memory result or the writeback value. The whole block is combinational. A decision for the instruction now in execute appears at the outputs in the same cycle as its inputs. The pipeline registers, the register file, stall detection and branch handling stay outside the block.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory write flag is high, its destination is nonzero and equals an operand's source register, that operand's select is 2'b10 and its output equals `exmResult`.
- R2: When the memory/writeback write flag is high, its destination is nonzero and equals an operand's source register, and R1 does not apply to that operand, the select is 2'b01 and the output equals `wbValue`.
- R3: A stage whose write flag is low never causes forwarding, even when its destination matches the source register.
- R4: A destination register number of 0 never causes forwarding. The operand keeps 2'b00 and the register-file value.
- R5: When both older stages match the same operand, the execute/memory result wins, with select 2'b10.
- R6: Operand A (`srcRegA`, `selA`, `opA`) and operand B (`srcRegB`, `selB`, `opB`) are decided independently. Both may forward in the same cycle, with equal or different codes.
- R7: With no qualifying match, the select is 2'b00 and the output equals the register-file value for that operand.
- R8: The select code 2'b11 is never produced on either operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcRegA | input | 5 | Source register number of operand A of the instruction in execute |
| srcRegB | input | 5 | Source register number of operand B of the instruction in execute |
| exmDst | input | 5 | Destination register number held in the execute/memory slot |
| exmWrEn | input | 1 | Register write flag of the execute/memory instruction |
| wbDst | input | 5 | Destination register number held in the memory/writeback slot |
| wbWrEn | input | 1 | Register write flag of the memory/writeback instruction |
| rfValA | input | 32 | Operand A value read from the register file in decode |
| rfValB | input | 32 | Operand B value read from the register file in decode |
| exmResult | input | 32 | ALU result held in the execute/memory slot |
| wbValue | input | 32 | Value being written back from the memory/writeback slot |
| selA | output | 2 | Forwarding select for operand A |
| selB | output | 2 | Forwarding select for operand B |
| opA | output | 32 | Selected operand A for the ALU |
| opB | output | 32 | Selected operand B for the ALU |

## Verification
The bench runs three write-back chains. In the first, one producer is read at distances one, two and three: a design that forwarded at distance three, or picked the wrong stage at distance two, would hand the ALU a stale or wrong value. In the second, three writes in a row target one register: a design without newest-first priority would return the older writeback value instead of the fresh ALU result. In the third, writes go to register zero and writes are made with the flag low: a design that skipped either qualifier would overwrite the hardwired zero or an unwritten register with garbage. A pseudo-random sweep over a small register range forces frequent collisions between the two operands and both stages, and so shows any coupling between the operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_EXM = 2'b10
  } fwdSel_e;

  localparam int NUM_OPS = 2;

  typedef struct packed {
    fwdSel_e selB;
    fwdSel_e selA;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] srcRegA,
  input  logic [REG_ADDR_W-1:0] srcRegB,
  input  logic [REG_ADDR_W-1:0] exmDst,
  input  logic                  exmWrEn,
  input  logic [REG_ADDR_W-1:0] wbDst,
  input  logic                  wbWrEn,
  output fwdStrobes_t           strobes
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic exmLive;
  logic wbLive;
  logic [REG_ADDR_W-1:0] srcRegs [NUM_OPS];
  fwdSel_e sels [NUM_OPS];

  // A producer counts only when it writes and its target is not the hardwired zero register
  assign exmLive = exmWrEn && (exmDst != ZERO_REG);
  assign wbLive  = wbWrEn && (wbDst != ZERO_REG);

  assign srcRegs[0] = srcRegA;
  assign srcRegs[1] = srcRegB;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    logic hitExm;
    logic hitWb;

    assign hitExm = exmLive && (exmDst == srcRegs[op]);
    assign hitWb  = wbLive && (wbDst == srcRegs[op]);

    // The newer producer is checked first
    always_comb begin
      if (hitExm)     sels[op] = SEL_EXM;
      else if (hitWb) sels[op] = SEL_WB;
      else            sels[op] = SEL_RF;
    end
  end

  assign strobes.selA = sels[0];
  assign strobes.selB = sels[1];

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] rfValA,
  input  logic [DATA_W-1:0] rfValB,
  input  logic [DATA_W-1:0] exmResult,
  input  logic [DATA_W-1:0] wbValue,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);

  logic [DATA_W-1:0] rfVals [NUM_OPS];
  logic [DATA_W-1:0] ops    [NUM_OPS];
  fwdSel_e           sels   [NUM_OPS];

  assign rfVals[0] = rfValA;
  assign rfVals[1] = rfValB;
  assign sels[0]   = strobes.selA;
  assign sels[1]   = strobes.selB;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
    always_comb begin
      unique case (sels[op])
        SEL_EXM: ops[op] = exmResult;
        SEL_WB:  ops[op] = wbValue;
        default: ops[op] = rfVals[op]; // the unused code 11 also selects the register file
      endcase
    end
  end

  assign opA = ops[0];
  assign opB = ops[1];

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input  logic [REG_ADDR_W-1:0] srcRegA,
  input  logic [REG_ADDR_W-1:0] srcRegB,
  input  logic [REG_ADDR_W-1:0] exmDst,
  input  logic                  exmWrEn,
  input  logic [REG_ADDR_W-1:0] wbDst,
  input  logic                  wbWrEn,
  input  logic [DATA_W-1:0]     rfValA,
  input  logic [DATA_W-1:0]     rfValB,
  input  logic [DATA_W-1:0]     exmResult,
  input  logic [DATA_W-1:0]     wbValue,
  output logic [1:0]            selA,
  output logic [1:0]            selB,
  output logic [DATA_W-1:0]     opA,
  output logic [DATA_W-1:0]     opB
);

  fwdStrobes_t strobes;

  fwd_ctrl #(
    .REG_ADDR_W(REG_ADDR_W)
  ) i_ctrl (
    .srcRegA(srcRegA),
    .srcRegB(srcRegB),
    .exmDst (exmDst),
    .exmWrEn(exmWrEn),
    .wbDst  (wbDst),
    .wbWrEn (wbWrEn),
    .strobes(strobes)
  );

  fwd_datapath #(
    .DATA_W(DATA_W)
  ) i_dp (
    .strobes  (strobes),
    .rfValA   (rfValA),
    .rfValB   (rfValB),
    .exmResult(exmResult),
    .wbValue  (wbValue),
    .opA      (opA),
    .opB      (opB)
  );

  assign selA = strobes.selA;
  assign selB = strobes.selB;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input logic [REG_ADDR_W-1:0] srcRegA,
  input logic [REG_ADDR_W-1:0] srcRegB,
  input logic [REG_ADDR_W-1:0] exmDst,
  input logic                  exmWrEn,
  input logic [REG_ADDR_W-1:0] wbDst,
  input logic                  wbWrEn,
  input logic [DATA_W-1:0]     rfValA,
  input logic [DATA_W-1:0]     rfValB,
  input logic [DATA_W-1:0]     exmResult,
  input logic [DATA_W-1:0]     wbValue,
  input logic [1:0]            selA,
  input logic [1:0]            selB,
  input logic [DATA_W-1:0]     opA,
  input logic [DATA_W-1:0]     opB
);

  always_comb begin
    // R1 R5
    exm_hit_a_chk: assert (!(exmWrEn && exmDst != '0 && exmDst == srcRegA) || (selA == 2'b10 && opA == exmResult));
    // R1 R5
    exm_hit_b_chk: assert (!(exmWrEn && exmDst != '0 && exmDst == srcRegB) || (selB == 2'b10 && opB == exmResult));
    // R2
    wb_hit_a_chk: assert (!(wbWrEn && wbDst != '0 && wbDst == srcRegA && !(exmWrEn && exmDst != '0 && exmDst == srcRegA)) || (selA == 2'b01 && opA == wbValue));
    // R2
    wb_hit_b_chk: assert (!(wbWrEn && wbDst != '0 && wbDst == srcRegB && !(exmWrEn && exmDst != '0 && exmDst == srcRegB)) || (selB == 2'b01 && opB == wbValue));
    // R3 R4
    exm_qual_chk: assert (!((selA == 2'b10) || (selB == 2'b10)) || (exmWrEn && exmDst != '0));
    // R3 R4
    wb_qual_chk: assert (!((selA == 2'b01) || (selB == 2'b01)) || (wbWrEn && wbDst != '0));
    // R7
    rf_pass_a_chk: assert (selA != 2'b00 || opA == rfValA);
    // R7
    rf_pass_b_chk: assert (selB != 2'b00 || opB == rfValB);
    // R8
    no_code3_chk: assert (selA != 2'b11 && selB != 2'b11);
  end

endmodule

bind fwd_unit fwd_unit_chk #(
  .REG_ADDR_W(REG_ADDR_W),
  .DATA_W    (DATA_W)
) i_fwd_unit_chk (
  .srcRegA  (srcRegA),
  .srcRegB  (srcRegB),
  .exmDst   (exmDst),
  .exmWrEn  (exmWrEn),
  .wbDst    (wbDst),
  .wbWrEn   (wbWrEn),
  .rfValA   (rfValA),
  .rfValB   (rfValB),
  .exmResult(exmResult),
  .wbValue  (wbValue),
  .selA     (selA),
  .selB     (selB),
  .opA      (opA),
  .opB      (opB)
);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;

  localparam int AW = 5;
  localparam int DW = 32;

  typedef struct {
    logic [1:0]    sA;
    logic [1:0]    sB;
    logic [DW-1:0] oA;
    logic [DW-1:0] oB;
    string         tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] srcRegA = '0, srcRegB = '0, exmDst = '0, wbDst = '0;
  logic          exmWrEn = 1'b0, wbWrEn = 1'b0;
  logic [DW-1:0] rfValA = 32'h1111_0000, rfValB = 32'h2222_0000;
  logic [DW-1:0] exmResult = 32'hEEEE_0000, wbValue = 32'hBBBB_0000;
  logic [1:0]    selA, selB;
  logic [DW-1:0] opA, opB;

  int checks = 0;
  int failures = 0;
  bit driverDone = 1'b0;
  expItem_t sbQueue [$];

  fwd_unit i_fwd_unit (
    .srcRegA(srcRegA), .srcRegB(srcRegB), .exmDst(exmDst), .exmWrEn(exmWrEn),
    .wbDst(wbDst), .wbWrEn(wbWrEn), .rfValA(rfValA), .rfValB(rfValB),
    .exmResult(exmResult), .wbValue(wbValue), .selA(selA), .selB(selB),
    .opA(opA), .opB(opB)
  );

  // Reference from the requirements: newest qualified producer wins, else register file
  function automatic logic [1:0] refSel(input logic [AW-1:0] src);
    if (exmWrEn && exmDst != 0 && exmDst == src) return 2'b10;
    if (wbWrEn && wbDst != 0 && wbDst == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] refOp(input logic [1:0] s, input logic [DW-1:0] rf);
    case (s)
      2'b10:   return exmResult;
      2'b01:   return wbValue;
      default: return rf;
    endcase
  endfunction

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic ew, input logic [AW-1:0] ed,
                       input logic ww, input logic [AW-1:0] wd, input string tag);
    expItem_t it;
    @(negedge clk);
    srcRegA = a; srcRegB = b; exmWrEn = ew; exmDst = ed; wbWrEn = ww; wbDst = wd;
    rfValA = rfValA + 32'd3; rfValB = rfValB + 32'd5;
    exmResult = exmResult + 32'd7; wbValue = wbValue + 32'd11;
    it.sA = refSel(a); it.sB = refSel(b);
    it.oA = refOp(it.sA, rfValA); it.oB = refOp(it.sB, rfValB);
    it.tag = tag;
    sbQueue.push_back(it);
  endtask

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares one item per rising edge, after the inputs have settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQueue.size() > 0) begin
        expItem_t it;
        it = sbQueue.pop_front();
        cmp(it.tag, "selA", {30'd0, selA}, {30'd0, it.sA});
        cmp(it.tag, "selB", {30'd0, selB}, {30'd0, it.sB});
        cmp(it.tag, "opA", opA, it.oA);
        cmp(it.tag, "opB", opB, it.oB);
        cmp("R8", "no code 11", {31'd0, (selA == 2'b11 || selB == 2'b11)}, 32'd0);
      end
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R7: reset state, all inputs idle
    drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, "R7_reset");
    // Chain: producer writes r2, read at distances 1, 2, 3
    drive(5'd2, 5'd5, 1'b1, 5'd2, 1'b1, 5'd9, "R1_dist1");
    drive(5'd6, 5'd2, 1'b1, 5'd13, 1'b1, 5'd2, "R2_dist2");
    drive(5'd2, 5'd2, 1'b1, 5'd14, 1'b1, 5'd13, "R7_dist3");
    // Three writes to r1 in a row: both stages match
    drive(5'd1, 5'd3, 1'b1, 5'd1, 1'b1, 5'd1, "R5_double");
    drive(5'd4, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1, "R5_doubleB");
    // Write to register zero
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, "R4_zero_both");
    drive(5'd0, 5'd7, 1'b1, 5'd0, 1'b1, 5'd7, "R4_zero_exm");
    // Matching destination with write flag low
    drive(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8, "R3_noWrite");
    drive(5'd8, 5'd9, 1'b0, 5'd8, 1'b1, 5'd8, "R3_exmOff");
    // Both operands forward, same code and different codes
    drive(5'd2, 5'd2, 1'b1, 5'd2, 1'b0, 5'd0, "R6_sameCode");
    drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b1, 5'd4, "R6_diffCode");
    drive(5'd4, 5'd3, 1'b1, 5'd3, 1'b1, 5'd4, "R6_swapCode");
    // Sweep with a narrow register range to force collisions
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive({3'd0, lfsr[1:0]}, {3'd0, lfsr[3:2]}, lfsr[4], {3'd0, lfsr[6:5]},
            lfsr[7], {3'd0, lfsr[9:8]}, "R6_sweep");
    end
    repeat (3) @(posedge clk);
    driverDone = 1'b1;
  end

  initial begin
    fork
      begin
        wait (driverDone && sbQueue.size() == 0);
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule